// File: doc/BRIEF.md
# Sector Lock Register Bank

This block keeps the protection state of an eleven-sector flash array. Each sector owns one small lock register with three live bits: one blocks writes, one blocks reads, and one freezes the register itself. Software reaches the registers through a register-space request port. The array logic asks two questions about any array address: may this sector be read, and may it be written.

The write answer also depends on two active-low hardware protect pins. The top-boot pin guards only the uppermost sector. The general pin guards every other sector. The pins act only on the answers. They never change the register contents, and a register read never shows them.

Register requests use a valid/ready handshake. A read returns its byte on a response channel that has its own valid/ready pair. A new request is taken only when no response is pending, or when the pending response is being consumed in the same cycle. A stalled response holds its data steady.

Top module: `sector_lock_bank`

## Requirements
- R1: After reset every one of the eleven lock registers reads 01h.
- R2: In a lock register, bit 0 is write-lock, bit 1 is lock-down and bit 2 is read-lock. Bits 7 to 3 always read 0, so a write of FFh reads back as 07h.
- R3: The sector bases in the 19-bit space are 00000h, 02000h, 04000h and 08000h for sectors 0 to 3, and 10000h·(s−3) for sectors 4 to 10. A sector's register sits at its base plus 2. Reads of any other address return 00h, and writes to any other address change nothing.
- R4: Once lock-down is 1, writes to that register are ignored until the next reset.
- R5: may_read is 1 exactly when the queried sector's read-lock bit is 0.
- R6: For sector 10, may_write is 1 only when its write-lock bit is 0 and tbl_n is high.
- R7: For sectors 0 to 9, may_write is 1 only when the write-lock bit is 0 and wp_n is high. wp_n has no effect on sector 10, and tbl_n has no effect on sectors 0 to 9.
- R8: The pin levels never change register contents and never appear in read data.
- R9: Every address inside a sector's range selects that sector on the query port.
- R10: req_ready equals !rsp_valid || rsp_ready. Read data appears with rsp_valid in the cycle after acceptance. The data stays stable while rsp_valid is high and rsp_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Register-space byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 8 | Read response data |
| q_addr | input | 19 | Array address to query |
| tbl_n | input | 1 | Top-boot protect, active low |
| wp_n | input | 1 | General protect, active low |
| may_read | output | 1 | Queried sector is readable |
| may_write | output | 1 | Queried sector is writable |

## Verification
The query port is tried with the first, last and middle addresses of sectors of every size. This separates a correct range decode from one that only matches sector bases. The two pins are driven low one at a time against sectors 10, 9 and 3, which shows whether each pin guards only its own group. Register traffic covers the reset value, all-ones writes, lock-down followed by a clearing write, and the offsets next to each register. A stalled response channel confirms that requests are held off and that the response data does not change.

// File: rtl/seclock_pkg.sv
package seclock_pkg;
  localparam int ADDR_W  = 19;
  localparam int DATA_W  = 8;
  localparam int NSEC    = 11;
  localparam int SEC_W   = $clog2(NSEC);
  localparam int TOP_SEC = NSEC - 1;
  localparam int REG_OFS = 2;
  localparam int LOCK_W  = 3;

  typedef logic [SEC_W-1:0]  sec_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic rd_lock;
    logic down;
    logic wr_lock;
  } lock_t;

  localparam lock_t LOCK_RST = '{rd_lock: 1'b0, down: 1'b0, wr_lock: 1'b1};

  function automatic sec_t sec_of(addr_t a);
    if (a[ADDR_W-1:16] != '0) return sec_t'({1'b0, a[ADDR_W-1:16]} + 4'd3);
    else if (a[15])           return sec_t'(3);
    else if (a[14])           return sec_t'(2);
    else if (a[13])           return sec_t'(1);
    else                      return sec_t'(0);
  endfunction

  function automatic addr_t base_of(sec_t s);
    case (s)
      sec_t'(0): return addr_t'(0);
      sec_t'(1): return addr_t'(20'h02000);
      sec_t'(2): return addr_t'(20'h04000);
      sec_t'(3): return addr_t'(20'h08000);
      default:   return addr_t'({5'd0, s} - 9'd3) << 16;
    endcase
  endfunction
endpackage

// File: rtl/seclock_dec.sv
module seclock_dec
  import seclock_pkg::*;
(
  input  addr_t addr,
  output sec_t  sec,
  output logic  reg_hit
);
  always_comb begin
    sec     = sec_of(addr);
    reg_hit = (addr == base_of(sec) + addr_t'(REG_OFS));
  end
endmodule

// File: rtl/seclock_cell.sv
module seclock_cell
  import seclock_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  lock_t wr_val,
  output lock_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= LOCK_RST;
    else if (wr_en && !q.down) q <= wr_val;
  end

  AST_LOCKDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    q.down |=> $stable(q)); // R4
endmodule

// File: rtl/sector_lock_bank.sv
module sector_lock_bank
  import seclock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              tbl_n,
  input  logic              wp_n,
  output logic              may_read,
  output logic              may_write
);
  sec_t  r_sec, q_sec;
  logic  r_hit, q_hit_unused;
  logic  accept;
  lock_t regs [NSEC];
  lock_t r_sel, q_sel;

  seclock_dec u_rdec (.addr(req_addr), .sec(r_sec), .reg_hit(r_hit));
  seclock_dec u_qdec (.addr(q_addr),   .sec(q_sec), .reg_hit(q_hit_unused));

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  for (genvar i = 0; i < NSEC; i++) begin : g_cell
    seclock_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (accept && req_write && r_hit && (r_sec == sec_t'(i))),
      .wr_val (lock_t'(req_wdata[LOCK_W-1:0])),
      .q      (regs[i])
    );
  end

  always_comb begin
    r_sel = '0;
    q_sel = '0;
    for (int i = 0; i < NSEC; i++) begin
      if (r_sec == sec_t'(i)) r_sel = regs[i];
      if (q_sec == sec_t'(i)) q_sel = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= r_hit ? DATA_W'(r_sel) : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    may_read  = !q_sel.rd_lock;
    may_write = !q_sel.wr_lock && ((q_sec == sec_t'(TOP_SEC)) ? tbl_n : wp_n);
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R10
  AST_RDATA_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[DATA_W-1:LOCK_W] == '0); // R2
  AST_TOP_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_sec == sec_t'(TOP_SEC)) && !tbl_n |-> !may_write); // R6
  AST_WP_PIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_sec != sec_t'(TOP_SEC)) && !wp_n |-> !may_write); // R7
  AST_READ_FOLLOWS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    may_read |-> !q_sel.rd_lock); // R5
endmodule

// File: tb/sector_lock_bank_tb.sv
`timescale 1ns/1ps
module sector_lock_bank_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [18:0] req_addr = 0, q_addr = 0;
  logic [7:0] req_wdata = 0;
  logic tbl_n = 1, wp_n = 1;
  logic req_ready, rsp_valid, may_read, may_write;
  logic [7:0] rsp_rdata;
  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  sector_lock_bank u_dut (.*);

  function automatic logic [18:0] base(int s);
    case (s)
      0: return 19'h00000; 1: return 19'h02000;
      2: return 19'h04000; 3: return 19'h08000;
      default: return 19'((s - 3) << 16);
    endcase
  endfunction

  function automatic logic [18:0] last(int s);
    return (s == 10) ? 19'h7FFFF : base(s + 1) - 19'd1;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rsp_valid && rsp_ready) begin
    if (exp_q.size() == 0) chk("R10 unexpected response", 8'h01, 8'h00);
    else chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
  end

  task automatic issue(logic wr, logic [18:0] a, logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic rd(logic [18:0] a, logic [7:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    issue(0, a, 0);
  endtask

  task automatic wr(logic [18:0] a, logic [7:0] d);
    issue(1, a, d);
  endtask

  task automatic qchk(logic [18:0] a, logic t, logic w, logic er, logic ew, string tag);
    @(posedge clk); #1;
    q_addr = a; tbl_n = t; wp_n = w;
    @(negedge clk);
    chk({tag, " may_read"}, {7'd0, may_read}, {7'd0, er});
    chk({tag, " may_write"}, {7'd0, may_write}, {7'd0, ew});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R1 reset values
    for (int s = 0; s < 11; s++) rd(base(s) + 2, 8'h01, $sformatf("R1 reset sector %0d", s));
    // R5/R6/R9 defaults: readable, write-locked
    for (int s = 0; s < 11; s++) qchk(last(s), 1, 1, 1, 0, $sformatf("R9 default last of %0d", s));
    for (int s = 0; s < 11; s++) wr(base(s) + 2, 8'h00);
    for (int s = 0; s < 11; s++) qchk(base(s) + ((last(s) - base(s)) >> 1), 1, 1, 1, 1,
                                      $sformatf("R9 unlocked mid of %0d", s));
    qchk(19'h70000, 0, 1, 1, 0, "R6 tbl_n low top");
    qchk(19'h6FFFF, 0, 1, 1, 1, "R7 tbl_n no effect sector 9");
    qchk(19'h7ABCD, 1, 0, 1, 1, "R7 wp_n no effect top");
    qchk(19'h08000, 1, 0, 1, 0, "R7 wp_n low sector 3");
    qchk(19'h00000, 0, 0, 1, 0, "R7 wp_n low sector 0");
    // R8: pins low, registers still read 00
    @(posedge clk); #1 tbl_n = 0; wp_n = 0;
    rd(19'h70002, 8'h00, "R8 top reg with pins low");
    rd(19'h08002, 8'h00, "R8 sector 3 reg with pins low");
    drain();
    @(posedge clk); #1 tbl_n = 1; wp_n = 1;
    // R2 layout, R4 lock-down
    wr(19'h20002, 8'hFF);
    rd(19'h20002, 8'h07, "R2 all-ones write");
    wr(19'h20002, 8'h00);
    rd(19'h20002, 8'h07, "R4 write after lock-down");
    drain();
    qchk(19'h2FFFF, 1, 1, 0, 0, "R5 sector 5 fully locked");
    wr(19'h02002, 8'h04);
    qchk(19'h03FFF, 1, 1, 0, 1, "R5 read-lock only sector 1");
    wr(19'h02002, 8'h01);
    qchk(19'h02000, 1, 1, 1, 0, "R2 write-lock bit0 sector 1");
    // R3 unmapped offsets
    rd(19'h70000, 8'h00, "R3 read base offset 0");
    rd(19'h04003, 8'h00, "R3 read offset 3");
    wr(19'h70003, 8'h01);
    wr(19'h70001, 8'h01);
    rd(19'h70002, 8'h00, "R3 neighbours did not write");
    drain();
    qchk(19'h70000, 1, 1, 1, 1, "R3 top still writable");
    // R10 back-pressure
    @(posedge clk); #1 rsp_ready = 0;
    rd(19'h04002, 8'h00, "R10 stalled read data");
    repeat (3) begin
      @(negedge clk);
      chk("R10 rsp_valid held", {7'd0, rsp_valid}, 8'h01);
      chk("R10 req_ready low", {7'd0, req_ready}, 8'h00);
    end
    @(posedge clk); #1 rsp_ready = 1;
    drain();
    @(negedge clk);
    chk("R10 req_ready restored", {7'd0, req_ready}, 8'h01);
    // R4 until reset
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk); #1 rst_n = 1;
    rd(19'h20002, 8'h01, "R4 lock-down cleared by reset");
    drain();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule